// File: doc/BRIEF.md
# Photon-Counting Pixel Cell Logic

This block is the digital half of one detector pixel. Two discriminator outputs come into it: one fires when the input charge passes a low energy level, and the other fires when it passes a high energy level. The block decides, once per low-level pulse, whether the event fell inside the energy window between the two levels. Each accepted event advances a 13-bit counter. The counter steps through a maximal-length linear-feedback sequence instead of a binary one, and it stops at a terminal state after 8001 counts.

A shutter input gives the same flip-flops a second role. With the shutter low, the pixel counts. With the shutter high, every clock moves one bit from the previous pixel into this pixel and one bit on to the next pixel. A select input picks which chain is moved: the 13 counter bits, so that the image can be read out, or the 8 configuration bits, so that the pixel can be set up. The configuration holds two 3-bit threshold trims, a test-enable bit and a mask bit. The trims and the test enable are only driven out to the analog side. The mask bit stops the pixel from counting.

Top module: `pixel_count_cell`

## Requirements
- R1: After reset the counter holds the seed state 13'h1FFF, which stands for a count of zero, and all 8 configuration bits are 0.
- R2: With the shutter low, the counter takes exactly one sequence step at the first clock edge that samples the low-level input low after it was high, as long as the high-level input was never sampled high while the low-level input was high. The high-level input in the falling cycle itself does not matter.
- R3: An event is rejected, and the counter keeps its value, if the high-level input was sampled high in any cycle in which the low-level input was high. This includes the cycle in which both rise together.
- R4: If the high-level input was already high in the cycle before the low-level input rises, the logic works as a single discriminator and counts that event even though the high-level input overlaps it.
- R5: While the mask bit is 1, no event changes the counter.
- R6: While the shutter is high, no event changes the counter.
- R7: With the shutter high and the select input at 0, each clock moves the counter chain one place toward its top. ser_i enters at bit 0, and ser_o shows bit 12. A full read therefore returns the most significant bit first.
- R8: With the shutter high and the select input at 1, the configuration chain moves instead, with ser_i entering at bit 0 and ser_o showing bit 7. The counter does not change during these shifts, and the configuration does not change at any other time.
- R9: The configuration fields are laid out as follows: trim_lo_o is bits 2:0, trim_hi_o is bits 5:3, test_en_o is bit 6 and mask_o is bit 7. The first bit shifted in ends up in bit 7.
- R10: One sequence step maps state s to {s[11:0], s[12]^s[3]^s[2]^s[0]}.
- R11: After 8001 steps from the seed, the counter holds its terminal state and ignores any further events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock; it also serves as the shift clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| shutter_i | input | 1 | 0 = count events, 1 = shift |
| chain_sel_i | input | 1 | Shift target: 0 = counter, 1 = configuration |
| ser_i | input | 1 | Serial input from the previous pixel |
| ser_o | output | 1 | Serial output to the next pixel (top bit of the selected chain) |
| hit_lo_i | input | 1 | Low-level discriminator output |
| hit_hi_i | input | 1 | High-level discriminator output |
| mask_o | output | 1 | Mask configuration bit |
| test_en_o | output | 1 | Test-enable configuration bit |
| trim_lo_o | output | 3 | Trim for the low-level discriminator |
| trim_hi_o | output | 3 | Trim for the high-level discriminator |

## Verification
The bench covers the timing corners of the window decision. It sends a high pulse that arrives only in the last cycle of the low pulse, a high pulse that rises together with the low pulse, a high pulse that appears only in the falling cycle, a one-cycle low pulse and two pulses back to back. A design that samples the high level at the wrong moment would count a rejected event or drop a valid one. A design that treats rising edges as events would count twice. Single-discriminator mode is tested with a high pulse that covers the whole low pulse; a design without that mode would count nothing. The bench also loads a state three steps before the terminal one and keeps counting past it, which catches a counter that wraps around or stops one step early. An event that falls while the configuration is shifting catches a design that counts or disturbs the counter while the shutter is high.

// File: rtl/pxl_pkg.sv
package pxl_pkg;
    localparam int CNT_W       = 13;
    localparam int CFG_W       = 8;
    localparam int TRIM_W      = 3;
    localparam int COUNT_RANGE = 8001;
    localparam int PERIOD      = (1 << CNT_W) - 1;
    localparam int BACK_STEPS  = PERIOD - COUNT_RANGE;

    localparam logic [CNT_W-1:0] CNT_SEED = '1;
    // feedback taps for x^13 + x^4 + x^3 + x + 1
    localparam logic [CNT_W-1:0] FB_TAPS  = 13'b1_0000_0000_1101;

    typedef struct packed {
        logic              mask;
        logic              test_en;
        logic [TRIM_W-1:0] trim_hi;
        logic [TRIM_W-1:0] trim_lo;
    } cfg_t;

    function automatic logic [CNT_W-1:0] lfsr_fwd(input logic [CNT_W-1:0] s);
        return {s[CNT_W-2:0], ^(s & FB_TAPS)};
    endfunction

    function automatic logic [CNT_W-1:0] lfsr_back(input logic [CNT_W-1:0] s);
        logic [CNT_W-2:0] low;
        logic             top;
        low = s[CNT_W-1:1];
        top = s[0] ^ (^(low & FB_TAPS[CNT_W-2:0]));
        return {top, low};
    endfunction

    // the terminal state lies COUNT_RANGE steps after the seed, which is
    // BACK_STEPS steps before it on the closed cycle
    function automatic logic [CNT_W-1:0] lfsr_terminal();
        logic [CNT_W-1:0] s;
        s = CNT_SEED;
        for (int i = 0; i < BACK_STEPS; i++) s = lfsr_back(s);
        return s;
    endfunction

    localparam logic [CNT_W-1:0] CNT_TERM = lfsr_terminal();
endpackage

// File: rtl/pxl_window.sv
module pxl_window (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic hit_lo_i,
    input  logic hit_hi_i,
    output logic event_o
);
    typedef struct packed {
        logic lo;
        logic hi;
        logic hi_seen;
        logic single;
    } win_t;

    win_t s_d, s_q;
    logic rise, fall;

    always_comb begin
        s_d    = s_q;
        s_d.lo = hit_lo_i;
        s_d.hi = hit_hi_i;
        rise   = hit_lo_i & ~s_q.lo;
        fall   = ~hit_lo_i & s_q.lo;
        if (rise) begin
            s_d.hi_seen = hit_hi_i;
            s_d.single  = s_q.hi;
        end else if (hit_lo_i) begin
            s_d.hi_seen = s_q.hi_seen | hit_hi_i;
            s_d.single  = s_q.single;
        end else begin
            s_d.hi_seen = 1'b0;
            s_d.single  = 1'b0;
        end
        event_o = fall & (s_q.single | ~s_q.hi_seen);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end
endmodule

// File: rtl/pxl_lfsr_count.sv
module pxl_lfsr_count
    import pxl_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             count_en_i,
    input  logic             shift_en_i,
    input  logic             ser_i,
    output logic [CNT_W-1:0] state_o,
    output logic             ser_o
);
    logic [CNT_W-1:0] st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_en_i)
            st_d = {st_q[CNT_W-2:0], ser_i};
        else if (count_en_i && st_q != CNT_TERM)
            st_d = lfsr_fwd(st_q);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= CNT_SEED;
        else         st_q <= st_d;
    end

    assign state_o = st_q;
    assign ser_o   = st_q[CNT_W-1];
endmodule

// File: rtl/pxl_cfg_reg.sv
module pxl_cfg_reg
    import pxl_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             shift_en_i,
    input  logic             ser_i,
    output logic [CFG_W-1:0] cfg_o,
    output logic             ser_o
);
    logic [CFG_W-1:0] cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (shift_en_i) cfg_d = {cfg_q[CFG_W-2:0], ser_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cfg_q <= '0;
        else         cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;
    assign ser_o = cfg_q[CFG_W-1];
endmodule

// File: rtl/pixel_count_cell.sv
module pixel_count_cell
    import pxl_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              shutter_i,
    input  logic              chain_sel_i,
    input  logic              ser_i,
    output logic              ser_o,
    input  logic              hit_lo_i,
    input  logic              hit_hi_i,
    output logic              mask_o,
    output logic              test_en_o,
    output logic [TRIM_W-1:0] trim_lo_o,
    output logic [TRIM_W-1:0] trim_hi_o
);
    logic             win_event;
    logic             cnt_shift, cfg_shift, cnt_count;
    logic             cnt_ser, cfg_ser;
    logic [CNT_W-1:0] cnt_state;
    logic [CFG_W-1:0] cfg_state;
    cfg_t             cfg_f;

    assign cfg_f     = cfg_t'(cfg_state);
    assign cnt_shift = shutter_i & ~chain_sel_i;
    assign cfg_shift = shutter_i &  chain_sel_i;
    assign cnt_count = win_event & ~shutter_i & ~cfg_f.mask;

    pxl_window win_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .hit_lo_i (hit_lo_i),
        .hit_hi_i (hit_hi_i),
        .event_o  (win_event)
    );

    pxl_lfsr_count cnt_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .count_en_i (cnt_count),
        .shift_en_i (cnt_shift),
        .ser_i      (ser_i),
        .state_o    (cnt_state),
        .ser_o      (cnt_ser)
    );

    pxl_cfg_reg cfg_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .shift_en_i (cfg_shift),
        .ser_i      (ser_i),
        .cfg_o      (cfg_state),
        .ser_o      (cfg_ser)
    );

    assign ser_o     = chain_sel_i ? cfg_ser : cnt_ser;
    assign mask_o    = cfg_f.mask;
    assign test_en_o = cfg_f.test_en;
    assign trim_lo_o = cfg_f.trim_lo;
    assign trim_hi_o = cfg_f.trim_hi;
endmodule

// File: rtl/pixel_count_cell_chk.sv
module pixel_count_cell_chk
    import pxl_pkg::*;
(
    input logic             clk_i,
    input logic             rst_ni,
    input logic             shutter_i,
    input logic             chain_sel_i,
    input logic             ser_i,
    input logic             mask_o,
    input logic [CNT_W-1:0] cnt_state,
    input logic [CFG_W-1:0] cfg_state
);
    // R2: while counting, the state either holds or takes exactly one step
    assert_one_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !shutter_i |=> (cnt_state == $past(cnt_state)) || (cnt_state == lfsr_fwd($past(cnt_state))));

    assert_mask_no_count_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!shutter_i && mask_o) |=> $stable(cnt_state));

    // R6 and R7: with the shutter high on the counter chain, the state only shifts
    assert_cnt_shift_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (shutter_i && !chain_sel_i) |=>
            (cnt_state == {$past(cnt_state[CNT_W-2:0]), $past(ser_i)}));

    assert_cnt_hold_cfg_shift_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (shutter_i && chain_sel_i) |=> $stable(cnt_state));

    assert_cfg_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!shutter_i || !chain_sel_i) |=> $stable(cfg_state));

    assert_no_overflow_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!shutter_i && cnt_state == CNT_TERM) |=> (cnt_state == CNT_TERM));
endmodule

bind pixel_count_cell pixel_count_cell_chk chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .shutter_i   (shutter_i),
    .chain_sel_i (chain_sel_i),
    .ser_i       (ser_i),
    .mask_o      (mask_o),
    .cnt_state   (cnt_state),
    .cfg_state   (cfg_state)
);

// File: tb/pixel_count_cell_tb_top.sv
`timescale 1ns/1ps
module pixel_count_cell_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       shutter = 1'b0, sel = 1'b0, ser_in = 1'b0;
    logic       hit_lo = 1'b0, hit_hi = 1'b0;
    logic       ser_out, mask, test_en;
    logic [2:0] trim_lo, trim_hi;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    logic [12:0] seq [0:8001];

    always #2.5 clk = ~clk;

    pixel_count_cell dut_i (
        .clk_i(clk), .rst_ni(rst_n), .shutter_i(shutter), .chain_sel_i(sel),
        .ser_i(ser_in), .ser_o(ser_out), .hit_lo_i(hit_lo), .hit_hi_i(hit_hi),
        .mask_o(mask), .test_en_o(test_en), .trim_lo_o(trim_lo), .trim_hi_o(trim_hi)
    );

    // stimulus vectors: lo and hi per cycle (bit 0 first), mask, expected events, requirement
    typedef struct packed {
        logic [5:0] lo;
        logic [5:0] hi;
        logic       msk;
        logic [1:0] n;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{6'b001110, 6'b000000, 1'b0, 2'd1, 4'd2},  // R2 clean window hit
        '{6'b001110, 6'b000100, 1'b0, 2'd0, 4'd3},  // R3 high mid-pulse
        '{6'b001110, 6'b001000, 1'b0, 2'd0, 4'd3},  // R3 high in last low cycle
        '{6'b001110, 6'b010000, 1'b0, 2'd1, 4'd2},  // R2 high only in falling cycle
        '{6'b000110, 6'b000110, 1'b0, 2'd0, 4'd3},  // R3 rising together
        '{6'b001100, 6'b011111, 1'b0, 2'd1, 4'd4},  // R4 single discriminator
        '{6'b011011, 6'b000000, 1'b0, 2'd2, 4'd2},  // R2 two pulses
        '{6'b000010, 6'b000000, 1'b0, 2'd1, 4'd2},  // R2 one-cycle pulse
        '{6'b001110, 6'b000000, 1'b1, 2'd0, 4'd5},  // R5 masked
        '{6'b001100, 6'b011111, 1'b1, 2'd0, 4'd5}   // R5 masked single mode
    };

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic read_count(output logic [12:0] v);
        shutter = 1'b1; sel = 1'b0; #1;
        v = '0;
        for (int i = 0; i < 13; i++) begin
            v = {v[11:0], ser_out};
            ser_in = ser_out;
            @(negedge clk);
        end
        shutter = 1'b0;
    endtask

    task automatic write_count(input logic [12:0] v);
        shutter = 1'b1; sel = 1'b0;
        for (int i = 12; i >= 0; i--) begin
            ser_in = v[i];
            @(negedge clk);
        end
        shutter = 1'b0;
    endtask

    task automatic write_cfg(input logic [7:0] v);
        shutter = 1'b1; sel = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            ser_in = v[i];
            @(negedge clk);
        end
        shutter = 1'b0; sel = 1'b0;
    endtask

    task automatic pulses(input int n);
        for (int k = 0; k < n; k++) begin
            hit_lo = 1'b1; @(negedge clk);
            hit_lo = 1'b0; @(negedge clk);
        end
    endtask

    initial begin
        seq[0] = 13'h1FFF;
        for (int i = 1; i <= 8001; i++)
            seq[i] = {seq[i-1][11:0], seq[i-1][12] ^ seq[i-1][3] ^ seq[i-1][2] ^ seq[i-1][0]};
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [12:0] v;
        logic [12:0] v2;
        int idx;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check({mask, test_en, trim_hi, trim_lo} == 8'h00, "R1 cfg", {mask, test_en, trim_hi, trim_lo}, 0);
        read_count(v);
        check(v == seq[0], "R1 count", v, seq[0]);

        // R7 readout order and circular restore
        write_count(13'h0A5C);
        shutter = 1'b1; sel = 1'b0; #1;
        check(ser_out == 1'b0, "R7 first bit out is bit 12", ser_out, 0);
        read_count(v);
        check(v == 13'h0A5C, "R7 read", v, 13'h0A5C);
        read_count(v);
        check(v == 13'h0A5C, "R7 reread", v, 13'h0A5C);

        // R2 R3 R4 R5 R10 vector walk
        write_count(seq[0]);
        idx = 0;
        foreach (VECS[j]) begin
            write_cfg({VECS[j].msk, 7'b0});
            for (int c = 0; c < 6; c++) begin
                hit_lo = VECS[j].lo[c];
                hit_hi = VECS[j].hi[c];
                @(negedge clk);
            end
            hit_lo = 1'b0; hit_hi = 1'b0;
            repeat (2) @(negedge clk);
            idx += int'(VECS[j].n);
            read_count(v);
            check(v == seq[idx], $sformatf("R%0d vector %0d", VECS[j].req, j), v, seq[idx]);
        end
        write_cfg(8'h00);

        // R10 single step from a mid-sequence state
        write_count(seq[100]);
        pulses(1);
        read_count(v);
        check(v == seq[101], "R10 step", v, seq[101]);

        // R9 field layout
        write_cfg(8'b1_0_101_011);
        check(mask == 1'b1 && test_en == 1'b0, "R9 flags", {mask, test_en}, 2'b10);
        check(trim_hi == 3'd5 && trim_lo == 3'd3, "R9 trims", {trim_hi, trim_lo}, {3'd5, 3'd3});
        write_cfg(8'b0_1_010_110);
        check({mask, test_en, trim_hi, trim_lo} == 8'b0_1_010_110, "R9 second pattern",
              {mask, test_en, trim_hi, trim_lo}, 8'b0_1_010_110);

        // R6 R8 event during circular config shift
        write_count(seq[20]);
        write_cfg(8'b0101_1010);
        shutter = 1'b1; sel = 1'b1; #1;
        for (int i = 0; i < 8; i++) begin
            ser_in = ser_out;
            hit_lo = (i == 2 || i == 3);
            @(negedge clk);
        end
        hit_lo = 1'b0; shutter = 1'b0; sel = 1'b0;
        repeat (2) @(negedge clk);
        check({mask, test_en, trim_hi, trim_lo} == 8'b0101_1010, "R8 cfg after circulate",
              {mask, test_en, trim_hi, trim_lo}, 8'b0101_1010);
        read_count(v);
        check(v == seq[20], "R6 R8 count untouched", v, seq[20]);

        // R8 counting leaves config alone
        pulses(3);
        check({mask, test_en, trim_hi, trim_lo} == 8'b0101_1010, "R8 cfg after counting",
              {mask, test_en, trim_hi, trim_lo}, 8'b0101_1010);
        read_count(v);
        check(v == seq[23], "R2 three counts", v, seq[23]);

        // R11 saturation
        write_count(seq[7998]);
        pulses(2);
        read_count(v);
        check(v == seq[8000], "R11 before terminal", v, seq[8000]);
        pulses(3);
        read_count(v);
        check(v == seq[8001], "R11 held at terminal", v, seq[8001]);
        pulses(1);
        read_count(v2);
        check(v2 == seq[8001], "R11 no wrap", v2, seq[8001]);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule